// File: doc/BRIEF.md
# Interrupt Gating and Sleep Wake-up Controller

This block merges the interrupt sources of a small microcontroller core into one request to the core. It also runs the sequence that takes the core out of sleep. There are two groups of sources. Core sources (timer overflow, external pin, port change) need only their own flag and enable. Peripheral sources also pass a shared group enable. The merged request, taken without the global enable, is the wake-up condition. The same request ANDed with the global enable is the interrupt sent to the core.

The block also generates the four-phase instruction clock, Q1 to Q4, from the oscillator clock. When a sleep request arrives with nothing pending, the phase clock stops. A source that becomes enabled produces a wake pulse. In crystal modes the phase clock restarts only after an oscillator start-up delay, and in external-clock mode it restarts at once. After restart the core finishes the instruction it already fetched and spends one dummy cycle. If the global enable was set at wake time, the block then strobes a vector load to address 0x0004, clears the global enable and hands back the saved in-line return address. Otherwise execution simply continues in-line.

Top module: `irq_wake_ctrl`

## Requirements
- R1: A source contributes to the merged request only when both its flag bit and its enable bit are 1.
- R2: Core sources (core_flag/core_en bits 0 timer overflow, 1 external pin, 2 port change) ignore peri_grp_en. The nine peripheral sources count only while peri_grp_en is 1, both while running and while asleep.
- R3: irq_core is the merged request ANDed with glb_en. The wake condition does not depend on glb_en.
- R4: Sources, enables and glb_en are captured only at the clock edge that ends Q1 while the phase clock runs, and every edge while it is stopped. A source that rises and falls between two Q1 edges has no effect on irq_core.
- R5: While clk_run is 1, q_phase is one-hot and steps Q1 (bit 0), Q2 (bit 1), Q3 (bit 2), Q4 (bit 3), then back to Q1. While clk_run is 0, q_phase is 0.
- R6: A sleep_req seen at the edge ending Q1, with no enabled source pending, stops the phase clock: clk_run goes to 0 at that edge.
- R7: If an enabled source is pending (glb_en ignored) when sleep is requested, sleep is not entered and clk_run stays 1.
- R8: While asleep, an enabled source is captured at one edge, and wake is high for exactly the following clock cycle.
- R9: With osc_ext = 0 (crystal mode), clk_run rises 1024 clock edges after the edge that ends the wake cycle.
- R10: With osc_ext = 1 (external clock), clk_run rises at the edge that ends the wake cycle, with no start-up delay.
- R11: If glb_en was captured as 1 at wake time, vec_load and gie_clr pulse for one clock in Q1 of the third instruction cycle after restart (8 clocks after restart). vec_addr is 0x0004 and ret_addr holds the next_pc value seen in the wake cycle.
- R12: If glb_en was captured as 0 at wake time, neither vec_load nor gie_clr pulses after restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_flag | input | 3 | Core source flags (timer, pin, port change) |
| core_en | input | 3 | Core source enables |
| peri_flag | input | 9 | Peripheral source flags |
| peri_en | input | 9 | Peripheral source enables |
| peri_grp_en | input | 1 | Peripheral group enable |
| glb_en | input | 1 | Global interrupt enable |
| sleep_req | input | 1 | Request to enter sleep |
| osc_ext | input | 1 | 1 = external clock mode (no start-up delay) |
| next_pc | input | 13 | In-line next instruction address |
| wake | output | 1 | One-cycle wake-up pulse |
| irq_core | output | 1 | Interrupt request to the core |
| q_phase | output | 4 | One-hot instruction phase Q1..Q4 |
| clk_run | output | 1 | Phase clock running |
| vec_load | output | 1 | Vector load strobe |
| vec_addr | output | 13 | Vector address (0x0004) |
| ret_addr | output | 13 | Saved return address |
| gie_clr | output | 1 | Strobe to clear the global enable |

## Verification
A change on a running source reaches irq_core at the next Q1 edge, at most four clocks later, so the bench holds each gating pattern for a full instruction cycle before it reads the output. While asleep, wake is due in the clock after the edge that captures the source. clk_run is due 1025 clock edges after that capture edge in crystal mode and one edge after it in external mode. The bench counts edges until the restart, compares the count, then steps eight more edges to the vector slot. It checks that vec_load stays low on every edge in between. All outputs are read at the falling edge, half a period after the edge that updates them.

// File: rtl/irq_wake_pkg.sv
`timescale 1ns/1ps
package irq_wake_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_START = 2'd2,
    ST_POST  = 2'd3
  } ctl_state_e;

  localparam int PHASES      = 4;
  localparam int POST_INSTRS = 2;

  // one-hot phase: bit 0 = Q1 ... bit 3 = Q4
  function automatic logic [3:0] phase_onehot(input logic [1:0] ph);
    return 4'b0001 << ph;
  endfunction

  // two-level gating: core hits bypass the group enable
  function automatic logic gate_combine(input logic core_hit, input logic peri_hit,
                                        input logic grp);
    return core_hit | (peri_hit & grp);
  endfunction
endpackage

// File: rtl/irq_gate_tree.sv
`timescale 1ns/1ps
module irq_gate_tree #(
  parameter int N_CORE = 3,
  parameter int N_PERI = 9
) (
  input  logic [N_CORE-1:0] cf,
  input  logic [N_CORE-1:0] ce,
  input  logic [N_PERI-1:0] pf,
  input  logic [N_PERI-1:0] pe,
  input  logic              grp,
  output logic              any_hit
);
  import irq_wake_pkg::*;

  logic [N_CORE-1:0] c_hit;
  logic [N_PERI-1:0] p_hit;

  for (genvar i = 0; i < N_CORE; i++) begin : g_core
    assign c_hit[i] = cf[i] & ce[i];
  end
  for (genvar j = 0; j < N_PERI; j++) begin : g_peri
    assign p_hit[j] = pf[j] & pe[j];
  end

  assign any_hit = gate_combine(|c_hit, |p_hit, grp);
endmodule

// File: rtl/startup_timer.sv
`timescale 1ns/1ps
module startup_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (!run) cnt <= '0;
    else          cnt <= cnt + W'(1);
  end

  assign done = run && (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/irq_wake_ctrl.sv
`timescale 1ns/1ps
module irq_wake_ctrl #(
  parameter int N_CORE  = 3,
  parameter int N_PERI  = 9,
  parameter int STARTUP = 1024,
  parameter int PC_W    = 13,
  parameter int VEC     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CORE-1:0] core_flag,
  input  logic [N_CORE-1:0] core_en,
  input  logic [N_PERI-1:0] peri_flag,
  input  logic [N_PERI-1:0] peri_en,
  input  logic              peri_grp_en,
  input  logic              glb_en,
  input  logic              sleep_req,
  input  logic              osc_ext,
  input  logic [PC_W-1:0]   next_pc,
  output logic              wake,
  output logic              irq_core,
  output logic [3:0]        q_phase,
  output logic              clk_run,
  output logic              vec_load,
  output logic [PC_W-1:0]   vec_addr,
  output logic [PC_W-1:0]   ret_addr,
  output logic              gie_clr
);
  import irq_wake_pkg::*;

  localparam logic [1:0] LAST_PH  = 2'(PHASES - 1);
  localparam logic [1:0] VEC_INST = 2'(POST_INSTRS);

  ctl_state_e        state;
  logic [1:0]        ph;
  logic [1:0]        icnt;
  logic              take_vec;

  // sampled copies of the request inputs
  logic [N_CORE-1:0] s_cf, s_ce;
  logic [N_PERI-1:0] s_pf, s_pe;
  logic              s_grp, s_gie;

  // named internal events
  logic smp_en;
  logic live_any;
  logic wake_any;
  logic in_startup;
  logic tmr_done;
  logic sleep_go;

  assign clk_run    = (state == ST_RUN) || (state == ST_POST);
  assign in_startup = (state == ST_START);
  assign smp_en     = !clk_run || (ph == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cf <= '0; s_ce <= '0; s_pf <= '0; s_pe <= '0;
      s_grp <= 1'b0; s_gie <= 1'b0;
    end else if (smp_en) begin
      s_cf <= core_flag; s_ce <= core_en;
      s_pf <= peri_flag; s_pe <= peri_en;
      s_grp <= peri_grp_en; s_gie <= glb_en;
    end
  end

  irq_gate_tree #(.N_CORE(N_CORE), .N_PERI(N_PERI)) u_gate_live (
    .cf(core_flag), .ce(core_en), .pf(peri_flag), .pe(peri_en),
    .grp(peri_grp_en), .any_hit(live_any)
  );

  irq_gate_tree #(.N_CORE(N_CORE), .N_PERI(N_PERI)) u_gate_smp (
    .cf(s_cf), .ce(s_ce), .pf(s_pf), .pe(s_pe),
    .grp(s_grp), .any_hit(wake_any)
  );

  startup_timer #(.LIMIT(STARTUP)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(in_startup), .done(tmr_done)
  );

  assign sleep_go = (state == ST_RUN) && (ph == 2'd0) && sleep_req && !live_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      ph       <= 2'd0;
      icnt     <= 2'd0;
      take_vec <= 1'b0;
      ret_addr <= '0;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (sleep_go) begin
            state <= ST_SLEEP;
            ph    <= 2'd0;
          end else begin
            ph <= ph + 2'd1;
          end
        end
        ST_SLEEP: begin
          if (wake_any) begin
            take_vec <= s_gie;
            ret_addr <= next_pc;
            if (osc_ext) begin
              state <= ST_POST;
              ph    <= 2'd0;
              icnt  <= 2'd0;
            end else begin
              state <= ST_START;
            end
          end
        end
        ST_START: begin
          if (tmr_done) begin
            state <= ST_POST;
            ph    <= 2'd0;
            icnt  <= 2'd0;
          end
        end
        ST_POST: begin
          ph <= ph + 2'd1;
          if (ph == LAST_PH) icnt <= icnt + 2'd1;
          if (ph == 2'd0 && icnt == VEC_INST) state <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign wake     = (state == ST_SLEEP) && wake_any;
  assign irq_core = wake_any && s_gie;
  assign q_phase  = clk_run ? phase_onehot(ph) : 4'b0000;
  assign vec_load = (state == ST_POST) && (ph == 2'd0) && (icnt == VEC_INST) && take_vec;
  assign gie_clr  = vec_load;
  assign vec_addr = PC_W'(VEC);
endmodule

// File: rtl/irq_wake_chk.sv
`timescale 1ns/1ps
module irq_wake_chk #(
  parameter int STARTUP = 1024,
  parameter int PC_W    = 13,
  parameter int VEC     = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wake,
  input logic            irq_core,
  input logic [3:0]      q_phase,
  input logic            clk_run,
  input logic            vec_load,
  input logic [PC_W-1:0] vec_addr,
  input logic            in_startup,
  input logic            tmr_done,
  input logic            samp_any
);
  int st_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          st_cnt <= 0;
    else if (in_startup) st_cnt <= st_cnt + 1;
    else                 st_cnt <= 0;
  end

  // R5
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_run |-> ($countones(q_phase) == 1));
  // R5
  phase_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_run |-> (q_phase == 4'b0000));
  // R5
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_run && q_phase[3]) |=> q_phase[0]);
  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_run && !q_phase[0]) |=> $stable(irq_core));
  // R3
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_core |-> samp_any);
  // R8
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
  // R8
  wake_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !clk_run);
  // R9
  startup_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_startup && tmr_done) |-> (st_cnt == STARTUP - 1));
  // R11
  vec_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |-> (q_phase[0] && vec_addr == PC_W'(VEC)));
endmodule

bind irq_wake_ctrl irq_wake_chk #(.STARTUP(STARTUP), .PC_W(PC_W), .VEC(VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wake(wake), .irq_core(irq_core), .q_phase(q_phase),
  .clk_run(clk_run), .vec_load(vec_load), .vec_addr(vec_addr),
  .in_startup(in_startup), .tmr_done(tmr_done), .samp_any(wake_any)
);

// File: tb/test_irq_wake_ctrl.sv
`timescale 1ns/1ps
module test_irq_wake_ctrl;
  localparam int NC = 3, NP = 9, SU = 1024, PW = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0] core_flag = '0, core_en = '0;
  logic [NP-1:0] peri_flag = '0, peri_en = '0;
  logic peri_grp_en = 1'b0, glb_en = 1'b0, sleep_req = 1'b0, osc_ext = 1'b0;
  logic [PW-1:0] next_pc = '0;
  logic wake, irq_core, clk_run, vec_load, gie_clr;
  logic [3:0] q_phase;
  logic [PW-1:0] vec_addr, ret_addr;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_wake_ctrl i_irq_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .core_flag(core_flag), .core_en(core_en),
    .peri_flag(peri_flag), .peri_en(peri_en), .peri_grp_en(peri_grp_en),
    .glb_en(glb_en), .sleep_req(sleep_req), .osc_ext(osc_ext), .next_pc(next_pc),
    .wake(wake), .irq_core(irq_core), .q_phase(q_phase), .clk_run(clk_run),
    .vec_load(vec_load), .vec_addr(vec_addr), .ret_addr(ret_addr), .gie_clr(gie_clr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic clear_src();
    core_flag = '0; core_en = '0; peri_flag = '0; peri_en = '0;
  endtask

  task automatic wait_q1();
    do @(negedge clk); while (q_phase !== 4'b0001);
  endtask

  task automatic sleep_now();
    wait_q1();
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
    chk("R6 clk_run after sleep", {31'd0, clk_run}, 32'd0);
    chk("R5 q_phase stopped", {28'd0, q_phase}, 32'd0);
  endtask

  // called at a negedge right after a source was raised while asleep
  task automatic expect_wake(input logic exp_vec, input logic ext, input logic [PW-1:0] pc);
    int k;
    bit early;
    tick();
    chk("R8 wake high", {31'd0, wake}, 32'd1);
    tick();
    chk("R8 wake single", {31'd0, wake}, 32'd0);
    k = 1;
    while (!clk_run && k < 3000) begin tick(); k++; end
    if (ext) chk("R10 restart edges", k, 32'd1);
    else     chk("R9 restart edges", k, SU + 1);
    chk("R5 restart at Q1", {28'd0, q_phase}, 32'd1);
    early = 0;
    for (int i = 0; i < 7; i++) begin
      tick();
      if (vec_load || gie_clr) early = 1;
    end
    chk("R11 no early vector", {31'd0, early}, 32'd0);
    tick();
    if (exp_vec) begin
      chk("R11 vec_load", {31'd0, vec_load}, 32'd1);
      chk("R11 gie_clr", {31'd0, gie_clr}, 32'd1);
      chk("R11 vec_addr", vec_addr, 32'd4);
      chk("R11 ret_addr", ret_addr, pc);
      tick();
      chk("R11 vec_load one cycle", {31'd0, vec_load}, 32'd0);
    end else begin
      chk("R12 no vec_load", {31'd0, vec_load}, 32'd0);
      chk("R12 no gie_clr", {31'd0, gie_clr}, 32'd0);
    end
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic exp;
    int st;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R5 reset q_phase", {28'd0, q_phase}, 32'd1);
    chk("R5 reset clk_run", {31'd0, clk_run}, 32'd1);
    chk("R3 reset irq_core", {31'd0, irq_core}, 32'd0);
    chk("R8 reset wake", {31'd0, wake}, 32'd0);
    chk("R11 reset vec_load", {31'd0, vec_load}, 32'd0);

    // R1 R2 R3: sweep each source over flag/enable, group and global enable
    for (int src = 0; src < NC + NP; src++)
      for (int fe = 0; fe < 4; fe++)
        for (int g = 0; g < 2; g++)
          for (int ge = 0; ge < 2; ge++) begin
            clear_src();
            if (src < NC) begin core_flag[src] = fe[1]; core_en[src] = fe[0]; end
            else begin peri_flag[src-NC] = fe[1]; peri_en[src-NC] = fe[0]; end
            peri_grp_en = g[0]; glb_en = ge[0];
            repeat (4) tick();
            exp = (fe == 3) && (src < NC || g == 1) && (ge == 1);
            chk($sformatf("R1 R2 R3 gating src=%0d fe=%0d g=%0d ge=%0d", src, fe, g, ge),
                {31'd0, irq_core}, {31'd0, exp});
          end
    clear_src(); glb_en = 1'b0; peri_grp_en = 1'b0;

    // R5: phase rotation
    wait_q1();
    for (int i = 1; i < 9; i++) begin
      tick();
      chk("R5 rotation", {28'd0, q_phase}, 32'd1 << (i % 4));
    end

    // R4: pulse between Q1 edges is not captured
    glb_en = 1'b1;
    do @(negedge clk); while (q_phase !== 4'b0010);
    core_flag[0] = 1'b1; core_en[0] = 1'b1;
    tick(); tick();
    clear_src();
    seen = 0;
    for (int i = 0; i < 6; i++) begin tick(); if (irq_core) seen = 1; end
    chk("R4 short pulse ignored", {31'd0, seen}, 32'd0);
    glb_en = 1'b0;

    // R7: pending source blocks sleep
    peri_grp_en = 1'b1; peri_flag[4] = 1'b1; peri_en[4] = 1'b1;
    wait_q1();
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
    chk("R7 stays running", {31'd0, clk_run}, 32'd1);
    repeat (8) tick();
    chk("R7 still running", {31'd0, clk_run}, 32'd1);
    clear_src(); peri_grp_en = 1'b0;
    repeat (4) tick();

    // R2 in sleep: gated peripheral ignored; then core pin wakes, crystal, vector
    osc_ext = 1'b0; glb_en = 1'b1;
    sleep_now();
    peri_flag[0] = 1'b1; peri_en[0] = 1'b1;
    seen = 0;
    for (int i = 0; i < 10; i++) begin tick(); if (wake || clk_run) seen = 1; end
    chk("R2 gated peripheral no wake", {31'd0, seen}, 32'd0);
    core_flag[1] = 1'b1; core_en[1] = 1'b1; next_pc = 13'h0123;
    expect_wake(1'b1, 1'b0, 13'h0123);
    clear_src(); repeat (4) tick();

    // R10 R12: external clock, global enable clear, peripheral source
    osc_ext = 1'b1; glb_en = 1'b0; peri_grp_en = 1'b1;
    sleep_now();
    repeat (3) tick();
    peri_flag[7] = 1'b1; peri_en[7] = 1'b1; next_pc = 13'h0456;
    expect_wake(1'b0, 1'b1, 13'h0456);
    clear_src(); repeat (4) tick();

    // R3 R10 R11: wake regardless of glb_en value capture, external, vector
    glb_en = 1'b1;
    sleep_now();
    core_flag[2] = 1'b1; core_en[2] = 1'b1; next_pc = 13'h1abc;
    expect_wake(1'b1, 1'b1, 13'h1abc);
    clear_src(); repeat (4) tick();

    // R9 R12: crystal, global enable clear
    osc_ext = 1'b0; glb_en = 1'b0;
    sleep_now();
    core_flag[0] = 1'b1; core_en[0] = 1'b1; next_pc = 13'h0042;
    expect_wake(1'b0, 1'b0, 13'h0042);
    clear_src();
    st = 0;
    repeat (4) tick();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule